// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block carries internal read and write requests onto an external bus whose 32 lines hold the address in one cycle and the data in the cycles after it. A transfer starts with one address-phase clock. In that clock the block drives the 26-bit address and a 3-bit transfer-size code onto the shared lines and pulses an active-low start strobe. One or more data beats follow. A 32-byte line transfer is a wrapping burst of eight 32-bit beats. It starts at the word that was asked for and stays inside the aligned 32-byte block.

The requester holds `req_valid` and the request fields until it sees `req_ack`. For writes it presents the data word of the current beat on `req_wdata`. It moves on to the next word after each `beat_done` pulse. For reads, each completed beat raises `rd_valid` together with the sampled word and its word index. Beats come in transfer order. The external device stretches any beat by holding `bus_ready` low.

The address phase is decoded in the same clock as an idle-state request. A new request that appears in the clock after an acknowledge therefore starts at once, and chip-select stays asserted across the boundary.

Top module: `mpx_bus_master`

## Requirements
- R1: While idle with `req_valid` high, in that same clock `bus_start_n`, `bus_cs_n` and `bus_frame_n` are 0 and `bus_ad_oe` is 1. `bus_ad_o[25:0]` carries `req_addr`, `bus_ad_o[28:26]` is 0 and `bus_ad_o[31:29]` carries `req_size`.
- R2: Size codes are 000 byte, 001 16-bit, 010 32-bit, 011 64-bit and 1xx 32-byte line. They give 1, 1, 1, 2 and 8 data beats respectively.
- R3: `bus_start_n` is low for exactly one clock per transfer and stays high in every data beat and wait state.
- R4: `bus_cs_n` stays low from the address phase through the clock in which the final beat completes. The next clock returns it high only if no new request is waiting, so back-to-back transfers have no chip-select gap.
- R5: `bus_frame_n` is low in the address phase and in every beat except the final one. It is high throughout the final beat, including that beat's wait states.
- R6: A beat completes only in a clock where `bus_ready` is high. While `bus_ready` is low, `beat_done` stays 0 and the beat index and strobes hold.
- R7: The first beat's word index is `req_addr[4:2]`. A line burst then increments that index modulo 8. A 64-bit transfer toggles bit 0 of the index within its 8-byte pair. Single-beat sizes report `req_addr[4:2]`.
- R8: On writes, `bus_ad_oe` is 1 in data beats and `bus_ad_o` equals `req_wdata`. `beat_done` pulses at each completed beat, with `rd_valid` 0.
- R9: On reads, `bus_ad_oe` is 0 after the address phase. Each completed beat raises `rd_valid` with `rd_data` equal to `bus_ad_i` in that clock.
- R10: `req_ack` pulses once per transfer, in the clock where the final beat completes, and in no other clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Transfer-size code |
| req_addr | input | 26 | Byte address |
| req_wdata | input | 32 | Write word for the current beat |
| req_ack | output | 1 | Transfer finished |
| beat_done | output | 1 | A data beat completed this clock |
| beat_word | output | 3 | Word index of the current beat within the 32-byte block |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| bus_ad_o | output | 32 | Shared address/data lines, driven value |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_i | input | 32 | Shared address/data lines, sampled value |
| bus_start_n | output | 1 | Address-phase strobe, active low |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_frame_n | output | 1 | Frame strobe, active low |
| bus_ready | input | 1 | Beat-completion input from the device |

## Verification
The assertions assume a requester that keeps `req_valid` and the request fields steady from the address phase until `req_ack`. They also assume a device that drives `bus_ready` to a known level in every data-phase clock. The wait-state checks accept a changing `req_wdata` during a stretched beat, because holding the write word is the requester's job, and they only demand a steady beat index and steady strobes. The stimulus changes inputs just after each rising edge. It holds each request until its acknowledge, and it changes the write word only after the beat that consumed it. Two of the transfers are issued back to back so that the no-gap chip-select case is reached.

// File: rtl/mpx_pkg.sv
`timescale 1ns/1ps
package mpx_pkg;
  typedef enum logic [2:0] {
    SZ_BYTE = 3'b000,
    SZ_HALF = 3'b001,
    SZ_WORD = 3'b010,
    SZ_DBL  = 3'b011,
    SZ_LINE = 3'b100
  } xfer_size_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } seq_state_e;
endpackage

// File: rtl/mpx_beat_seq.sv
`timescale 1ns/1ps
module mpx_beat_seq #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] wrap_mask,
  output logic [IDX_W-1:0] cur_idx,
  output logic             last
);
  logic [IDX_W-1:0] base_q, base_d;
  logic [IDX_W-1:0] mask_q, mask_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    mask_d = mask_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = start_idx;
      mask_d = wrap_mask;
      cnt_d  = '0;
    end else if (advance) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
    end else if (load || advance) begin
      base_q <= base_d;
      mask_q <= mask_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_idx = (base_q & ~mask_q) | ((base_q + cnt_q) & mask_q);
  assign last    = (cnt_q == mask_q);

  // R7: beat counter never leaves the wrap window
  p_count_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q & ~mask_q) == '0);
  // R7: a multi-beat step always moves to a new word
  p_step_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && mask_q != '0) |=> (cur_idx != $past(cur_idx)));
endmodule

// File: rtl/mpx_ctrl.sv
`timescale 1ns/1ps
module mpx_ctrl
  import mpx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic bus_ready,
  input  logic last,
  output logic addr_phase,
  output logic data_phase,
  output logic beat_done,
  output logic xfer_done
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    addr_phase = 1'b0;
    data_phase = 1'b0;
    beat_done  = 1'b0;
    xfer_done  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_phase = 1'b1;
          state_d    = ST_DATA;
        end
      end
      ST_DATA: begin
        data_phase = 1'b1;
        if (bus_ready) begin
          beat_done = 1'b1;
          if (last) begin
            xfer_done = 1'b1;
            state_d   = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R3: the address phase never lasts two clocks
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> !addr_phase);
  // R10: after the final beat the data phase is over
  p_done_leaves_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !data_phase);
endmodule

// File: rtl/mpx_bus_master.sv
`timescale 1ns/1ps
module mpx_bus_master #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [2:0]  req_size,
  input  logic [25:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        req_ack,
  output logic        beat_done,
  output logic [2:0]  beat_word,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic [31:0] bus_ad_o,
  output logic        bus_ad_oe,
  input  logic [31:0] bus_ad_i,
  output logic        bus_start_n,
  output logic        bus_cs_n,
  output logic        bus_frame_n,
  input  logic        bus_ready
);
  import mpx_pkg::*;

  localparam int LANE_B    = DATA_W / 8;
  localparam int LANE_W    = $clog2(LANE_B);
  localparam int BEATS     = LINE_BYTES / LANE_B;
  localparam int IDX_W     = $clog2(BEATS);
  localparam int PAD_W     = DATA_W - 3 - ADDR_W;
  localparam int DBL_BEATS = (8 / LANE_B) > 0 ? (8 / LANE_B) : 1;
  localparam logic [IDX_W-1:0] LINE_MASK = IDX_W'(BEATS - 1);
  localparam logic [IDX_W-1:0] DBL_MASK  = IDX_W'(DBL_BEATS - 1);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             addr_phase, data_phase, xfer_done, last;
  logic             wr_q;
  logic [IDX_W-1:0] wrap_mask, start_idx, cur_idx;

  always_comb begin
    if (req_size[2])             wrap_mask = LINE_MASK;
    else if (req_size == SZ_DBL) wrap_mask = DBL_MASK;
    else                         wrap_mask = '0;
  end
  assign start_idx = req_addr[LANE_W +: IDX_W];

  mpx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .bus_ready  (bus_ready),
    .last       (last),
    .addr_phase (addr_phase),
    .data_phase (data_phase),
    .beat_done  (beat_done),
    .xfer_done  (xfer_done)
  );

  mpx_beat_seq #(.IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (addr_phase),
    .advance   (beat_done && !last),
    .start_idx (start_idx),
    .wrap_mask (wrap_mask),
    .cur_idx   (cur_idx),
    .last      (last)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)     wr_q <= 1'b0;
    else if (addr_phase) wr_q <= req_write;
  end

  assign bus_start_n = !addr_phase;
  assign bus_cs_n    = !(addr_phase || data_phase);
  assign bus_frame_n = !(addr_phase || (data_phase && !last));
  assign bus_ad_oe   = addr_phase || (data_phase && wr_q);
  assign bus_ad_o    = addr_phase ? {req_size, {PAD_W{1'b0}}, req_addr} : req_wdata;
  assign req_ack     = xfer_done;
  assign beat_word   = cur_idx;
  assign rd_valid    = beat_done && !wr_q;
  assign rd_data     = bus_ad_i;

  // R5: frame is only ever asserted inside chip-select
  p_frame_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_frame_n |-> !bus_cs_n);
  // R5: the acknowledged beat is the one with frame negated
  p_ack_frame_off_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_ack |-> bus_frame_n);
  // R6: a stretched beat keeps its index and chip-select
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_cs_n && bus_start_n && !bus_ready) |=> ($stable(beat_word) && !bus_cs_n));
  // R9: read data is never returned while the block drives the lines
  p_read_released_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_valid |-> !bus_ad_oe);
endmodule

// File: tb/mpx_bus_master_bench.sv
`timescale 1ns/1ps
module mpx_bus_master_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [2:0]  req_size;
  logic [25:0] req_addr;
  logic [31:0] req_wdata;
  logic        req_ack, beat_done, rd_valid;
  logic [2:0]  beat_word;
  logic [31:0] rd_data, bus_ad_o, bus_ad_i;
  logic        bus_ad_oe, bus_start_n, bus_cs_n, bus_frame_n, bus_ready;

  always #5 clk = ~clk;

  mpx_bus_master u_mpx_bus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .beat_done(beat_done), .beat_word(beat_word),
    .rd_valid(rd_valid), .rd_data(rd_data), .bus_ad_o(bus_ad_o),
    .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i), .bus_start_n(bus_start_n),
    .bus_cs_n(bus_cs_n), .bus_frame_n(bus_frame_n), .bus_ready(bus_ready)
  );

  typedef struct {
    logic [2:0]  idx;
    logic [31:0] data;
    logic        rd;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // monitor: compare each completed beat with the scoreboard
  always @(negedge clk) begin
    if (rst_n && beat_done) begin
      if (q.size() == 0) begin
        check("R9 unexpected beat", 32'd1, 32'd0);
      end else begin
        e = q.pop_front();
        check("R7 beat word index", {29'd0, beat_word}, {29'd0, e.idx});
        if (e.rd) begin
          check("R9 read strobe", {31'd0, rd_valid}, 32'd1);
          check("R9 read data", rd_data, e.data);
        end else begin
          check("R8 no read strobe on write", {31'd0, rd_valid}, 32'd0);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic xfer(input logic wr, input logic [2:0] sz, input logic [25:0] a,
                      input int wait_beat, input int waits, input logic keep);
    int          n;
    logic [2:0]  st, idx;
    logic [31:0] d;
    n  = sz[2] ? 8 : ((sz == 3'b011) ? 2 : 1);
    st = a[4:2];
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = '0;
    @(negedge clk);
    check("R1 start_n", {31'd0, bus_start_n}, 32'd0);
    check("R1 R4 cs_n", {31'd0, bus_cs_n}, 32'd0);
    check("R1 frame_n", {31'd0, bus_frame_n}, 32'd0);
    check("R1 oe", {31'd0, bus_ad_oe}, 32'd1);
    check("R1 R2 address and size", bus_ad_o, {sz, 3'b000, a});
    @(posedge clk); #1;
    for (int k = 0; k < n; k++) begin
      if (sz[2])              idx = st + 3'(k);
      else if (sz == 3'b011)  idx = {st[2:1], st[0] ^ k[0]};
      else                    idx = st;
      d = 32'hC300_0000 ^ {6'd0, a} ^ (32'(k) << 20);
      q.push_back('{idx, d, !wr});
      for (int w = 0; w < ((k == wait_beat) ? waits : 0); w++) begin
        bus_ready = 1'b0; bus_ad_i = 32'hDEAD_BEEF;
        if (wr) req_wdata = d;
        @(negedge clk);
        check("R6 no beat while not ready", {31'd0, beat_done}, 32'd0);
        check("R6 cs held in wait", {31'd0, bus_cs_n}, 32'd0);
        check("R3 start high in wait", {31'd0, bus_start_n}, 32'd1);
        check("R5 frame in wait", {31'd0, bus_frame_n}, {31'd0, (k == n - 1)});
        check("R10 no ack in wait", {31'd0, req_ack}, 32'd0);
        @(posedge clk); #1;
      end
      bus_ready = 1'b1;
      bus_ad_i  = wr ? 32'hDEAD_BEEF : d;
      if (wr) req_wdata = d;
      @(negedge clk);
      check("R3 start high in beat", {31'd0, bus_start_n}, 32'd1);
      check("R4 cs in beat", {31'd0, bus_cs_n}, 32'd0);
      check("R5 frame in beat", {31'd0, bus_frame_n}, {31'd0, (k == n - 1)});
      check("R8 R9 line direction", {31'd0, bus_ad_oe}, {31'd0, wr});
      if (wr) check("R8 write data", bus_ad_o, d);
      check("R10 ack timing", {31'd0, req_ack}, {31'd0, (k == n - 1)});
      check("R6 beat on ready", {31'd0, beat_done}, 32'd1);
      @(posedge clk); #1;
    end
    bus_ready = 1'b0;
    if (!keep) begin
      req_valid = 1'b0;
      @(negedge clk);
      check("R4 cs released", {31'd0, bus_cs_n}, 32'd1);
      check("R5 frame idle", {31'd0, bus_frame_n}, 32'd1);
      check("R9 lines released", {31'd0, bus_ad_oe}, 32'd0);
      check("R3 no start when idle", {31'd0, bus_start_n}, 32'd1);
      check("R10 no ack when idle", {31'd0, req_ack}, 32'd0);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = '0;
    req_addr = '0; req_wdata = '0; bus_ad_i = '0; bus_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    check("R4 reset cs", {31'd0, bus_cs_n}, 32'd1);
    check("R3 reset start", {31'd0, bus_start_n}, 32'd1);
    check("R5 reset frame", {31'd0, bus_frame_n}, 32'd1);
    check("R10 reset ack", {31'd0, req_ack}, 32'd0);
    @(posedge clk); #1;

    xfer(1'b1, 3'b010, 26'h0123454, -1, 0, 1'b0);  // R2 32-bit write
    xfer(1'b0, 3'b000, 26'h0000ABC,  0, 2, 1'b0);  // R2 byte read with waits
    xfer(1'b0, 3'b011, 26'h000000C,  1, 1, 1'b0);  // R7 64-bit: words 3 then 2
    xfer(1'b0, 3'b100, 26'h0001234,  3, 2, 1'b1);  // R7 line read from word 5
    xfer(1'b1, 3'b111, 26'h0000040,  7, 3, 1'b1);  // R4 back to back, wait on last
    xfer(1'b1, 3'b001, 26'h3FFFFFE,  0, 0, 1'b0);  // R2 16-bit write at top
    repeat (2) @(posedge clk);
    check("R7 every beat seen", 32'(q.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule